// File: doc/BRIEF.md
# Control-Transfer Next-Address Unit

This purely combinational block sits beside the execute stage of a 32-bit pipeline that has one branch delay slot. For each instruction it decides where fetch goes next. It also reports whether the flow was redirected, whether a return address has to be written to the register file, and whether a trap was raised. Conditional branches compare two operands, or test one operand against zero. Region jumps keep the upper address bits of the slot address. Register jumps load the address from an operand. The two trap instructions send fetch to a fixed vector and hand back the faulting address.

The opcode selects the class of the instruction. Two classes need a second field. Opcode 000001 picks its zero-test condition from the rt field. Opcode 000000 picks register jumps and traps from the function field. The link variants fold the register-file write into the same decision as the condition test, so that one cycle yields both the next PC and the write-back request. All addresses are relative to the delay slot: the slot is at PC+4, and the return address is PC+8. Instructions that are not control transfers fall through to PC+4.

Top module: `npc_unit`

## Requirements
- R1: For any opcode/function/rt-field combination not listed in R2–R8, next_pc = pc+4, and redirect, link_en, trap all read 0, link_val and epc read 0.
- R2: Opcode 000100 redirects when rs == rt and opcode 000101 redirects when rs != rt. A redirect goes to pc+4 + (sign-extended 16-bit offset × 4). A branch that is not taken goes to pc+4.
- R3: Opcode 000110 redirects when rs ≤ 0 and opcode 000111 redirects when rs > 0. In both cases rs is read as signed two's complement, and the target is the one given in R2.
- R4: Under opcode 000001, rt field 00000 redirects when rs < 0 (signed) and rt field 00001 redirects when rs ≥ 0. No link is requested. Any other rt field code that R5 does not name is treated as R1.
- R5: Under opcode 000001, rt field 10000 tests rs < 0 and rt field 10001 tests rs ≥ 0. Both assert link_en with link_reg = 31 and link_val = pc+8, whether or not the branch is taken.
- R6: Opcode 000010 always redirects to {upper 4 bits of pc+4, 26-bit target, 2'b00}. Opcode 000011 goes to the same address and also links to register 31 with pc+8.
- R7: Opcode 000000 with function 001000 always redirects to rs. Function 001001 does the same and links the rd field with pc+8.
- R8: Opcode 000000 with function 001100 or 001101 sets trap = 1, next_pc = 0x3C and epc = pc. In this case redirect and link_en stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| rs_val_i | input | 32 | First source operand value |
| rt_val_i | input | 32 | Second source operand value |
| opcode_i | input | 6 | Primary opcode field |
| rt_sel_i | input | 5 | rt field (condition selector under opcode 000001) |
| rd_sel_i | input | 5 | rd field (link destination of the register jump with link) |
| funct_i | input | 6 | Function field under opcode 000000 |
| offset_i | input | 16 | Branch displacement in words |
| jtarget_i | input | 26 | Region jump word index |
| next_pc_o | output | 32 | Address to fetch next |
| redirect_o | output | 1 | Flow leaves the sequential path (taken branch or jump) |
| link_en_o | output | 1 | Request to write a return address |
| link_reg_o | output | 5 | Destination register for the return address |
| link_val_o | output | 32 | Return address (pc+8) |
| trap_o | output | 1 | Trap instruction seen |
| epc_o | output | 32 | Saved address for a trap |

## Verification
A link-and-branch instruction can request a register write in the same cycle that its condition fails. The link must then be raised, and the next address must still be the fall-through one. The sweep drives both link zero-test codes with rs at zero, one, minus one and the two extreme values. That makes each condition come out both ways, and the link fields and the next address are judged together against a model. A trap and a redirect must never coincide, so every function code under opcode 000000 is swept with every operand pattern.

// File: rtl/npc_pkg.sv
package npc_pkg;
  parameter int unsigned NPC_XLEN = 32;
  localparam int unsigned IMM_W = 16;
  localparam int unsigned JT_W  = 26;
  localparam int unsigned REG_W = 5;
  localparam int unsigned OP_W  = 6;
  localparam int unsigned REGION_W = NPC_XLEN - JT_W - 2;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
  localparam logic [OP_W-1:0] OP_REGIMM  = 6'b000001;
  localparam logic [OP_W-1:0] OP_J       = 6'b000010;
  localparam logic [OP_W-1:0] OP_JAL     = 6'b000011;
  localparam logic [OP_W-1:0] OP_BEQ     = 6'b000100;
  localparam logic [OP_W-1:0] OP_BNE     = 6'b000101;
  localparam logic [OP_W-1:0] OP_BLEZ    = 6'b000110;
  localparam logic [OP_W-1:0] OP_BGTZ    = 6'b000111;

  localparam logic [OP_W-1:0] FN_JR      = 6'b001000;
  localparam logic [OP_W-1:0] FN_JALR    = 6'b001001;
  localparam logic [OP_W-1:0] FN_SYSCALL = 6'b001100;
  localparam logic [OP_W-1:0] FN_BREAK   = 6'b001101;

  localparam logic [REG_W-1:0] RI_LTZ      = 5'b00000;
  localparam logic [REG_W-1:0] RI_GEZ      = 5'b00001;
  localparam logic [REG_W-1:0] RI_LTZ_LINK = 5'b10000;
  localparam logic [REG_W-1:0] RI_GEZ_LINK = 5'b10001;

  typedef logic [NPC_XLEN-1:0] word_t;

  typedef enum logic [2:0] {
    K_SEQ, K_BRANCH, K_REGION, K_REGISTER, K_TRAP
  } xfer_kind_e;

  typedef enum logic [2:0] {
    C_NEVER, C_EQ, C_NE, C_LEZ, C_GTZ, C_LTZ, C_GEZ
  } cond_e;

  // Address of the delay slot.
  function automatic word_t slot_addr(word_t pc);
    return pc + word_t'(4);
  endfunction

  // Return address: the instruction after the delay slot.
  function automatic word_t return_addr(word_t pc);
    return pc + word_t'(8);
  endfunction

  // Word displacement, sign-extended and scaled, added to the slot address.
  function automatic word_t rel_target(word_t base, logic [IMM_W-1:0] off);
    word_t ext;
    ext = {{(NPC_XLEN-IMM_W){off[IMM_W-1]}}, off};
    return base + (ext << 2);
  endfunction

  // Upper region bits of the slot address, word index below them.
  function automatic word_t region_target(word_t base, logic [JT_W-1:0] idx);
    return {base[NPC_XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [REG_W-1:0] rt_sel_i,
  input  logic [OP_W-1:0]  funct_i,
  output xfer_kind_e       kind_o,
  output cond_e            cond_o,
  output logic             link_fixed_o,
  output logic             link_rd_o
);
  always_comb begin
    kind_o       = K_SEQ;
    cond_o       = C_NEVER;
    link_fixed_o = 1'b0;
    link_rd_o    = 1'b0;
    case (opcode_i)
      OP_BEQ:  begin kind_o = K_BRANCH; cond_o = C_EQ;  end
      OP_BNE:  begin kind_o = K_BRANCH; cond_o = C_NE;  end
      OP_BLEZ: begin kind_o = K_BRANCH; cond_o = C_LEZ; end
      OP_BGTZ: begin kind_o = K_BRANCH; cond_o = C_GTZ; end
      OP_REGIMM: begin
        case (rt_sel_i)
          RI_LTZ:      begin kind_o = K_BRANCH; cond_o = C_LTZ; end
          RI_GEZ:      begin kind_o = K_BRANCH; cond_o = C_GEZ; end
          RI_LTZ_LINK: begin kind_o = K_BRANCH; cond_o = C_LTZ; link_fixed_o = 1'b1; end
          RI_GEZ_LINK: begin kind_o = K_BRANCH; cond_o = C_GEZ; link_fixed_o = 1'b1; end
          default: ;
        endcase
      end
      OP_J:   kind_o = K_REGION;
      OP_JAL: begin kind_o = K_REGION; link_fixed_o = 1'b1; end
      OP_SPECIAL: begin
        case (funct_i)
          FN_JR:      kind_o = K_REGISTER;
          FN_JALR:    begin kind_o = K_REGISTER; link_rd_o = 1'b1; end
          FN_SYSCALL: kind_o = K_TRAP;
          FN_BREAK:   kind_o = K_TRAP;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_comb begin
    if (link_rd_o) AST_RD_LINK_ONLY_SPECIAL: assert (opcode_i == OP_SPECIAL && !link_fixed_o)
      else $error("register-jump link outside opcode 0"); // R7
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  cond_e cond_i,
  input  word_t a_i,
  input  word_t b_i,
  output logic  pass_o
);
  logic a_neg, a_zero, a_eq_b;

  assign a_neg  = a_i[NPC_XLEN-1];
  assign a_zero = (a_i == '0);
  assign a_eq_b = (a_i == b_i);

  always_comb begin
    case (cond_i)
      C_EQ:    pass_o = a_eq_b;
      C_NE:    pass_o = !a_eq_b;
      C_LEZ:   pass_o = a_neg || a_zero;
      C_GTZ:   pass_o = !a_neg && !a_zero;
      C_LTZ:   pass_o = a_neg;
      C_GEZ:   pass_o = !a_neg;
      default: pass_o = 1'b0;
    endcase
  end

  always_comb begin
    if (cond_i == C_GTZ && pass_o) AST_GTZ_SIGNED: assert ($signed(a_i) > 0)
      else $error("positive test passed a non-positive operand"); // R3
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter word_t TRAP_VEC = 32'h0000_003C
) (
  input  xfer_kind_e       kind_i,
  input  logic             pass_i,
  input  word_t            pc_i,
  input  word_t            rs_i,
  input  logic [IMM_W-1:0] offset_i,
  input  logic [JT_W-1:0]  jtarget_i,
  output word_t            seq_pc_o,
  output word_t            next_pc_o,
  output logic             redirect_o
);
  word_t branch_dest, region_dest;

  assign seq_pc_o    = slot_addr(pc_i);
  assign branch_dest = rel_target(seq_pc_o, offset_i);
  assign region_dest = region_target(seq_pc_o, jtarget_i);

  always_comb begin
    redirect_o = 1'b0;
    next_pc_o  = seq_pc_o;
    case (kind_i)
      K_BRANCH: if (pass_i) begin
        redirect_o = 1'b1;
        next_pc_o  = branch_dest;
      end
      K_REGION:   begin redirect_o = 1'b1; next_pc_o = region_dest; end
      K_REGISTER: begin redirect_o = 1'b1; next_pc_o = rs_i; end
      K_TRAP:     next_pc_o = TRAP_VEC;
      default: ;
    endcase
  end

  always_comb begin
    if (!redirect_o && kind_i != K_TRAP) AST_FALL_THROUGH: assert (next_pc_o == pc_i + 32'd4)
      else $error("fall-through address wrong"); // R1
    if (kind_i == K_REGION) AST_REGION_KEEP: assert (next_pc_o[NPC_XLEN-1 -: REGION_W] == seq_pc_o[NPC_XLEN-1 -: REGION_W] && next_pc_o[1:0] == 2'b00)
      else $error("region jump lost upper bits"); // R6
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter word_t            TRAP_VEC = 32'h0000_003C,
  parameter logic [REG_W-1:0] LINK_REG = 5'd31
) (
  input  logic [31:0] pc_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  input  logic [5:0]  opcode_i,
  input  logic [4:0]  rt_sel_i,
  input  logic [4:0]  rd_sel_i,
  input  logic [5:0]  funct_i,
  input  logic [15:0] offset_i,
  input  logic [25:0] jtarget_i,
  output logic [31:0] next_pc_o,
  output logic        redirect_o,
  output logic        link_en_o,
  output logic [4:0]  link_reg_o,
  output logic [31:0] link_val_o,
  output logic        trap_o,
  output logic [31:0] epc_o
);
  xfer_kind_e kind;
  cond_e      cond;
  logic       link_fixed, link_rd, cond_pass;
  word_t      seq_pc;

  npc_decode u_decode (
    .opcode_i    (opcode_i),
    .rt_sel_i    (rt_sel_i),
    .funct_i     (funct_i),
    .kind_o      (kind),
    .cond_o      (cond),
    .link_fixed_o(link_fixed),
    .link_rd_o   (link_rd)
  );

  npc_cond u_cond (
    .cond_i(cond),
    .a_i   (rs_val_i),
    .b_i   (rt_val_i),
    .pass_o(cond_pass)
  );

  npc_target #(.TRAP_VEC(TRAP_VEC)) u_target (
    .kind_i    (kind),
    .pass_i    (cond_pass),
    .pc_i      (pc_i),
    .rs_i      (rs_val_i),
    .offset_i  (offset_i),
    .jtarget_i (jtarget_i),
    .seq_pc_o  (seq_pc),
    .next_pc_o (next_pc_o),
    .redirect_o(redirect_o)
  );

  // Link is independent of the condition outcome.
  assign link_en_o  = link_fixed || link_rd;
  assign link_reg_o = link_rd ? rd_sel_i : (link_fixed ? LINK_REG : '0);
  assign link_val_o = link_en_o ? return_addr(pc_i) : '0;
  assign trap_o     = (kind == K_TRAP);
  assign epc_o      = trap_o ? pc_i : '0;

  always_comb begin
    if (trap_o) AST_TRAP_VECTOR: assert (next_pc_o == TRAP_VEC && epc_o == pc_i && !redirect_o && !link_en_o)
      else $error("trap outputs inconsistent"); // R8
    if (link_en_o) AST_LINK_AFTER_SLOT: assert (link_val_o == seq_pc + 32'd4)
      else $error("return address not after delay slot"); // R5
    if (link_en_o && opcode_i != OP_SPECIAL) AST_LINK_R31: assert (link_reg_o == LINK_REG)
      else $error("fixed link register wrong"); // R5
    if (opcode_i == OP_BEQ && rs_val_i == rt_val_i) AST_EQ_TAKEN: assert (redirect_o)
      else $error("equal operands did not redirect"); // R2
  end
endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] pc, rs, rt, npc, lval, epc;
  logic [5:0]  op, fn;
  logic [4:0]  rts, rds, lreg;
  logic [15:0] off;
  logic [25:0] jt;
  logic        red, len, trp;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  npc_unit u_dut (
    .pc_i(pc), .rs_val_i(rs), .rt_val_i(rt), .opcode_i(op), .rt_sel_i(rts),
    .rd_sel_i(rds), .funct_i(fn), .offset_i(off), .jtarget_i(jt),
    .next_pc_o(npc), .redirect_o(red), .link_en_o(len), .link_reg_o(lreg),
    .link_val_o(lval), .trap_o(trp), .epc_o(epc)
  );

  task automatic apply_and_check(input logic [31:0] a_pc, input logic [31:0] a_rs,
      input logic [31:0] a_rt, input logic [5:0] a_op, input logic [4:0] a_rts,
      input logic [4:0] a_rds, input logic [5:0] a_fn, input logic [15:0] a_off,
      input logic [25:0] a_jt);
    logic [31:0] e_npc, e_lval, e_epc, p4, disp;
    logic [4:0]  e_lreg;
    logic        e_red, e_len, e_trp, cnd;
    string       tag;
    @(negedge clk);
    pc = a_pc; rs = a_rs; rt = a_rt; op = a_op; rts = a_rts; rds = a_rds;
    fn = a_fn; off = a_off; jt = a_jt;
    p4 = a_pc + 32'd4;
    disp = 32'($signed(a_off)) * 32'd4;
    e_npc = p4; e_red = 0; e_len = 0; e_lreg = 0; e_lval = 0; e_trp = 0; e_epc = 0;
    cnd = 0; tag = "R1";
    case (a_op)
      6'd4: begin tag = "R2"; cnd = (a_rs == a_rt); end
      6'd5: begin tag = "R2"; cnd = (a_rs != a_rt); end
      6'd6: begin tag = "R3"; cnd = ($signed(a_rs) <= 0); end
      6'd7: begin tag = "R3"; cnd = ($signed(a_rs) > 0); end
      6'd1: begin
        if (a_rts == 5'd0)  begin tag = "R4"; cnd = $signed(a_rs) < 0; end
        if (a_rts == 5'd1)  begin tag = "R4"; cnd = $signed(a_rs) >= 0; end
        if (a_rts == 5'd16) begin tag = "R5"; cnd = $signed(a_rs) < 0;
          e_len = 1; e_lreg = 5'd31; e_lval = a_pc + 32'd8; end
        if (a_rts == 5'd17) begin tag = "R5"; cnd = $signed(a_rs) >= 0;
          e_len = 1; e_lreg = 5'd31; e_lval = a_pc + 32'd8; end
      end
      6'd2, 6'd3: begin
        tag = "R6"; e_red = 1;
        e_npc = (p4 & 32'hF000_0000) | ({6'd0, a_jt} * 32'd4);
        if (a_op == 6'd3) begin e_len = 1; e_lreg = 5'd31; e_lval = a_pc + 32'd8; end
      end
      6'd0: begin
        if (a_fn == 6'd8 || a_fn == 6'd9) begin
          tag = "R7"; e_red = 1; e_npc = a_rs;
          if (a_fn == 6'd9) begin e_len = 1; e_lreg = a_rds; e_lval = a_pc + 32'd8; end
        end
        if (a_fn == 6'd12 || a_fn == 6'd13) begin
          tag = "R8"; e_trp = 1; e_npc = 32'h3C; e_epc = a_pc;
        end
      end
      default: ;
    endcase
    if (cnd) begin e_red = 1; e_npc = p4 + disp; end
    #1;
    n_run++;
    if (npc !== e_npc || red !== e_red || len !== e_len || lreg !== e_lreg ||
        lval !== e_lval || trp !== e_trp || epc !== e_epc) begin
      n_fail++;
      $display("FAIL %s op=%0d rt=%0d fn=%0d: got npc=%h red=%b len=%b lreg=%0d lval=%h trap=%b epc=%h exp npc=%h red=%b len=%b lreg=%0d lval=%h trap=%b epc=%h",
        tag, a_op, a_rts, a_fn, npc, red, len, lreg, lval, trp, epc,
        e_npc, e_red, e_len, e_lreg, e_lval, e_trp, e_epc);
    end
  endtask

  logic [31:0] pcs [3];
  logic [31:0] rsv [6];
  logic [15:0] offs [4];

  initial begin
    pcs[0] = 32'h0040_0100; pcs[1] = 32'h0FFF_FFFC; pcs[2] = 32'hF000_2000;
    rsv[0] = 32'd0; rsv[1] = 32'd1; rsv[2] = 32'hFFFF_FFFF;
    rsv[3] = 32'h7FFF_FFFF; rsv[4] = 32'h8000_0000; rsv[5] = 32'h0000_1230;
    offs[0] = 16'h0000; offs[1] = 16'h0003; offs[2] = 16'hFFFF; offs[3] = 16'h8000;
    pc = 0; rs = 0; rt = 0; op = 0; rts = 0; rds = 0; fn = 0; off = 0; jt = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: quiescent all-zero word falls through to pc+4
    apply_and_check(32'd0, 32'd0, 32'd0, 6'd0, 5'd0, 5'd0, 6'd0, 16'd0, 26'd0);
    for (int o = 0; o < 64; o++) begin
      int nsub;
      nsub = (o == 0) ? 64 : ((o == 1) ? 32 : 1);
      for (int s = 0; s < nsub; s++)
        for (int p = 0; p < 3; p++)
          for (int a = 0; a < 6; a++)
            for (int b = 0; b < 3; b++)
              for (int m = 0; m < 4; m++) begin
                logic [31:0] tv;
                logic [4:0]  rsel;
                logic [5:0]  fsel;
                tv = (b == 0) ? rsv[a] : ((b == 1) ? 32'd0 : 32'h8000_0000);
                rsel = (o == 1) ? 5'(s) : 5'(s + m * 7);
                fsel = (o == 0) ? 6'(s) : 6'(a * 11);
                apply_and_check(pcs[p], rsv[a], tv, 6'(o), rsel, 5'(s + p + m),
                  fsel, offs[m], 26'(o * 1237 + s * 97 + m * 13 + 26'h155_5555));
              end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected sweep completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule